// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores incoming frames into a circular receive area of local packet memory. Memory is split into pages of 2^OFS_W bytes (256 by default), and a page number is the upper PG_W bits of a memory byte address. Software programs four page pointers:

- the first page of the ring;
- the page just past its last page;
- a boundary page that the host still owns;
- the current page, where the next frame will be placed.

For every frame the block reserves a 4-byte header at offset 0 of the current page. It streams the frame bytes into the memory starting at offset 4, wrapping from the end of the ring back to its first page. When the frame ends cleanly, it fills in the header and moves the current page past the frame.

The block never writes into the boundary page. A frame that would reach it is abandoned. The block then raises the overwrite and missed flags and enters a halted state, and leaves that state once the host moves the boundary. In monitor mode frames are swallowed without touching memory and are counted as missed. Frames that end with an error are discarded, and the current page is left where it was.

Top module: `ring_rx_mgr`

## Requirements
- R1: After reset all page registers, the control bit and all four flags read zero, and no memory write is issued.
- R2: Frame byte i is written to the address {page, offset}. The first byte goes to offset 4 of the current page, and each later byte goes to the next offset. When a page's last offset is reached, writing continues at offset 0 of the following page.
- R3: The page that follows the last ring page (the page whose successor equals the stop register) is the first ring page. This applies to the data write address and to the next-page pointer.
- R4: After a good frame of length L, the header bytes at offsets 0..3 of the starting page hold the following: the rx_status sampled with rx_eof; the next page, zero-extended; the low byte of L+4; the high byte of L+4.
- R5: After the header is written, the current page becomes the starting page advanced by ceil((L+4)/page size) pages, using the wrap of R3.
- R6: Flag bit 0 (received OK) is set once per committed frame. Writing ones to register 5 clears flag bits 0 (OK), 1 (overwrite) and 2 (missed). Register 5 reads {4'b0, halted, missed, overwrite, ok}.
- R7: A byte that would land in the boundary page, or a frame that starts while the current page equals the boundary, causes the following: nothing is written to that page, the overwrite, missed and halted flags are set, no header is written and the current page is unchanged.
- R8: While halted, incoming frames cause no memory writes and no flag changes. Writing the boundary register with its present value keeps the block halted. Writing a different value clears the halted state.
- R9: With control bit 0 (monitor) set, a frame produces no memory writes, sets the missed flag, and leaves the current page unchanged.
- R10: A frame whose rx_eof comes with rx_err set gets no header. Flag bit 0 is not set, and the current page is unchanged.
- R11: The register map is 0 first page, 1 stop page, 2 boundary, 3 current page, 4 control and 5 flags. Values written to registers 0 to 4 read back on cfg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| rx_sof | input | 1 | Frame start strobe, carries no byte |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | Frame end strobe, carries no byte; at least 4 idle cycles must follow |
| rx_err | input | 1 | Frame is bad, sampled with rx_eof |
| rx_status | input | 8 | Status byte for the header, sampled with rx_eof |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PG_W+OFS_W | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| irq_rx_ok | output | 1 | Received OK flag |
| irq_overwrite | output | 1 | Ring overwrite flag |
| st_missed | output | 1 | Missed frame flag |
| st_halted | output | 1 | Halted after overwrite |

## Verification
The bench builds the block with 4-bit page numbers and 16-byte pages, over an eight-page ring from page 2 to page 9. Frames of every length from 0 to 60 bytes then fill one to four pages each. The current page therefore laps the ring many times, and frames land on every page, including the end-of-ring wrap and frames that exactly fill their last page. Small pages make a boundary hit cheap to place both mid-frame and at frame start. Header contents, the next-page pointer and every data byte are predicted arithmetically and compared against a shadow memory built from the write port.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int CNT_W     = 16;
  localparam int HDR_BYTES = 4;

  localparam logic [2:0] SEL_FIRST = 3'd0;
  localparam logic [2:0] SEL_STOP  = 3'd1;
  localparam logic [2:0] SEL_BOUND = 3'd2;
  localparam logic [2:0] SEL_CURR  = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_FLAGS = 3'd5;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_DATA = 2'd1,
    WR_DROP = 2'd2,
    WR_HDR  = 2'd3
  } wr_state_e;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ring_page_step.sv
module ring_page_step #(
  parameter int PG_W = 8
) (
  input  logic [PG_W-1:0] pg,
  input  logic [PG_W-1:0] first,
  input  logic [PG_W-1:0] stop,
  output logic [PG_W-1:0] nxt
);
  logic [PG_W-1:0] inc;

  assign inc = pg + 1'b1;
  assign nxt = (inc == stop) ? first : inc;
endmodule

// File: rtl/ring_regs.sv
module ring_regs
  import ring_pkg::*;
#(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic            commit,
  input  logic [PG_W-1:0] commit_pg,
  input  logic            ovw_evt,
  input  logic            miss_evt,
  output logic [PG_W-1:0] first,
  output logic [PG_W-1:0] stop,
  output logic [PG_W-1:0] bound,
  output logic [PG_W-1:0] curr,
  output logic            monitor,
  output logic [3:0]      flags
);
  logic [PG_W-1:0] first_q, first_n, stop_q, stop_n;
  logic [PG_W-1:0] bound_q, bound_n, curr_q, curr_n;
  logic            mon_q, mon_n;
  logic            ok_q, ok_n, ovw_q, ovw_n, miss_q, miss_n, halt_q, halt_n;
  logic [PG_W-1:0] wpg;
  logic            upd_en;

  assign wpg    = cfg_wdata[PG_W-1:0];
  assign upd_en = cfg_we | commit | ovw_evt | miss_evt;

  always_comb begin
    first_n = first_q;
    stop_n  = stop_q;
    bound_n = bound_q;
    curr_n  = curr_q;
    mon_n   = mon_q;
    ok_n    = ok_q;
    ovw_n   = ovw_q;
    miss_n  = miss_q;
    halt_n  = halt_q;
    if (cfg_we) begin
      case (cfg_addr)
        SEL_FIRST: first_n = wpg;
        SEL_STOP:  stop_n  = wpg;
        SEL_BOUND: begin
          bound_n = wpg;
          if (wpg != bound_q) halt_n = 1'b0;
        end
        SEL_CURR:  curr_n  = wpg;
        SEL_CTRL:  mon_n   = cfg_wdata[0];
        SEL_FLAGS: begin
          ok_n   = ok_q   & ~cfg_wdata[0];
          ovw_n  = ovw_q  & ~cfg_wdata[1];
          miss_n = miss_q & ~cfg_wdata[2];
        end
        default: ;
      endcase
    end
    if (commit) begin
      curr_n = commit_pg;
      ok_n   = 1'b1;
    end
    if (ovw_evt) begin
      ovw_n  = 1'b1;
      halt_n = 1'b1;
    end
    if (miss_evt) miss_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      stop_q  <= '0;
      bound_q <= '0;
      curr_q  <= '0;
      mon_q   <= 1'b0;
      ok_q    <= 1'b0;
      ovw_q   <= 1'b0;
      miss_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else if (upd_en) begin
      first_q <= first_n;
      stop_q  <= stop_n;
      bound_q <= bound_n;
      curr_q  <= curr_n;
      mon_q   <= mon_n;
      ok_q    <= ok_n;
      ovw_q   <= ovw_n;
      miss_q  <= miss_n;
      halt_q  <= halt_n;
    end
  end

  always_comb begin
    case (cfg_addr)
      SEL_FIRST: cfg_rdata = 8'(first_q);
      SEL_STOP:  cfg_rdata = 8'(stop_q);
      SEL_BOUND: cfg_rdata = 8'(bound_q);
      SEL_CURR:  cfg_rdata = 8'(curr_q);
      SEL_CTRL:  cfg_rdata = {7'b0, mon_q};
      SEL_FLAGS: cfg_rdata = {4'b0, halt_q, miss_q, ovw_q, ok_q};
      default:   cfg_rdata = 8'h00;
    endcase
  end

  assign first   = first_q;
  assign stop    = stop_q;
  assign bound   = bound_q;
  assign curr    = curr_q;
  assign monitor = mon_q;
  assign flags   = {halt_q, miss_q, ovw_q, ok_q};
endmodule

// File: rtl/ring_wr_ctrl.sv
module ring_wr_ctrl
  import ring_pkg::*;
#(
  parameter int PG_W  = 8,
  parameter int OFS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_sof,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_eof,
  input  logic                  rx_err,
  input  logic [7:0]            rx_status,
  input  logic [PG_W-1:0]       first,
  input  logic [PG_W-1:0]       stop,
  input  logic [PG_W-1:0]       bound,
  input  logic [PG_W-1:0]       curr,
  input  logic                  monitor,
  input  logic                  halted,
  output logic                  mem_we,
  output logic [PG_W+OFS_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  commit,
  output logic [PG_W-1:0]       commit_pg,
  output logic                  ovw_evt,
  output logic                  miss_evt
);
  localparam int ADDR_W = PG_W + OFS_W;

  wr_state_e        st_q, st_n;
  logic [PG_W-1:0]  wpg_q, wpg_n, nxt_q, nxt_n, wpg_inc;
  logic [OFS_W-1:0] woff_q, woff_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_hdr;
  logic [7:0]       stat_q, stat_n;
  logic [1:0]       hidx_q, hidx_n;
  logic             we_q, we_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [7:0]       wd_q, wd_n;

  ring_page_step #(.PG_W(PG_W)) u_step (
    .pg    (wpg_q),
    .first (first),
    .stop  (stop),
    .nxt   (wpg_inc)
  );

  assign cnt_hdr = cnt_q + CNT_W'(HDR_BYTES);

  always_comb begin
    st_n     = st_q;
    wpg_n    = wpg_q;
    woff_n   = woff_q;
    nxt_n    = nxt_q;
    cnt_n    = cnt_q;
    stat_n   = stat_q;
    hidx_n   = hidx_q;
    we_n     = 1'b0;
    addr_n   = addr_q;
    wd_n     = wd_q;
    commit   = 1'b0;
    ovw_evt  = 1'b0;
    miss_evt = 1'b0;
    case (st_q)
      WR_IDLE: begin
        if (rx_sof && !halted) begin
          cnt_n  = '0;
          wpg_n  = curr;
          woff_n = OFS_W'(HDR_BYTES);
          if (monitor) begin
            miss_evt = 1'b1;
            st_n     = WR_DROP;
          end else if (curr == bound) begin
            ovw_evt  = 1'b1;
            miss_evt = 1'b1;
            st_n     = WR_DROP;
          end else begin
            st_n = WR_DATA;
          end
        end
      end
      WR_DATA: begin
        if (rx_eof) begin
          if (rx_err) begin
            st_n = WR_IDLE;
          end else begin
            nxt_n  = (woff_q == '0) ? wpg_q : wpg_inc;
            stat_n = rx_status;
            hidx_n = 2'd0;
            st_n   = WR_HDR;
          end
        end else if (rx_valid) begin
          if (wpg_q == bound) begin
            ovw_evt  = 1'b1;
            miss_evt = 1'b1;
            st_n     = WR_DROP;
          end else begin
            we_n   = 1'b1;
            addr_n = {wpg_q, woff_q};
            wd_n   = rx_data;
            woff_n = woff_q + 1'b1;
            cnt_n  = cnt_q + 1'b1;
            if (&woff_q) wpg_n = wpg_inc;
          end
        end
      end
      WR_DROP: begin
        if (rx_eof) st_n = WR_IDLE;
      end
      WR_HDR: begin
        we_n   = 1'b1;
        addr_n = {curr, OFS_W'(hidx_q)};
        case (hidx_q)
          2'd0:    wd_n = stat_q;
          2'd1:    wd_n = 8'(nxt_q);
          2'd2:    wd_n = cnt_hdr[7:0];
          default: wd_n = cnt_hdr[15:8];
        endcase
        hidx_n = hidx_q + 1'b1;
        if (hidx_q == 2'd3) begin
          commit = 1'b1;
          st_n   = WR_IDLE;
        end
      end
      default: st_n = WR_IDLE;
    endcase
  end

  assign commit_pg = nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      wpg_q  <= '0;
      woff_q <= '0;
      nxt_q  <= '0;
      cnt_q  <= '0;
      stat_q <= '0;
      hidx_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_n;
      wpg_q  <= wpg_n;
      woff_q <= woff_n;
      nxt_q  <= nxt_n;
      cnt_q  <= cnt_n;
      stat_q <= stat_n;
      hidx_q <= hidx_n;
      we_q   <= we_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
endmodule

// File: rtl/ring_rx_mgr.sv
module ring_rx_mgr #(
  parameter int PG_W  = 8,
  parameter int OFS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  input  logic                  rx_sof,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_eof,
  input  logic                  rx_err,
  input  logic [7:0]            rx_status,
  output logic                  mem_we,
  output logic [PG_W+OFS_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  irq_rx_ok,
  output logic                  irq_overwrite,
  output logic                  st_missed,
  output logic                  st_halted
);
  logic            srst_n;
  logic [PG_W-1:0] ring_first, ring_stop, ring_bound, ring_curr, commit_pg;
  logic            monitor, commit, ovw_evt, miss_evt;
  logic [3:0]      flags;

  ring_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ring_regs #(.PG_W(PG_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .commit    (commit),
    .commit_pg (commit_pg),
    .ovw_evt   (ovw_evt),
    .miss_evt  (miss_evt),
    .first     (ring_first),
    .stop      (ring_stop),
    .bound     (ring_bound),
    .curr      (ring_curr),
    .monitor   (monitor),
    .flags     (flags)
  );

  ring_wr_ctrl #(.PG_W(PG_W), .OFS_W(OFS_W)) u_wr (
    .clk       (clk),
    .rst_n     (srst_n),
    .rx_sof    (rx_sof),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_eof    (rx_eof),
    .rx_err    (rx_err),
    .rx_status (rx_status),
    .first     (ring_first),
    .stop      (ring_stop),
    .bound     (ring_bound),
    .curr      (ring_curr),
    .monitor   (monitor),
    .halted    (flags[3]),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .commit    (commit),
    .commit_pg (commit_pg),
    .ovw_evt   (ovw_evt),
    .miss_evt  (miss_evt)
  );

  assign irq_rx_ok     = flags[0];
  assign irq_overwrite = flags[1];
  assign st_missed     = flags[2];
  assign st_halted     = flags[3];
endmodule

// File: rtl/ring_rx_chk.sv
module ring_rx_chk #(
  parameter int PG_W  = 8,
  parameter int OFS_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mem_we,
  input logic [PG_W+OFS_W-1:0] mem_addr,
  input logic [PG_W-1:0]       first,
  input logic [PG_W-1:0]       stop,
  input logic [PG_W-1:0]       bound,
  input logic                  irq_rx_ok,
  input logic                  irq_overwrite,
  input logic                  st_missed,
  input logic                  st_halted
);
  logic [PG_W-1:0] wr_pg;
  assign wr_pg = mem_addr[PG_W+OFS_W-1:OFS_W];

  a_r3_write_inside_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_pg >= first && wr_pg < stop));

  a_r7_bound_page_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_pg != bound));

  a_r7_overwrite_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_overwrite) |-> (st_halted && st_missed));

  a_r6_ok_with_header: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rx_ok) |-> (mem_we && mem_addr[OFS_W-1:0] == OFS_W'(3)));

  a_r8_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (st_halted && $past(st_halted)) |-> !mem_we);
endmodule

bind ring_rx_mgr ring_rx_chk #(.PG_W(PG_W), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst_n         (srst_n),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .first         (ring_first),
  .stop          (ring_stop),
  .bound         (ring_bound),
  .irq_rx_ok     (irq_rx_ok),
  .irq_overwrite (irq_overwrite),
  .st_missed     (st_missed),
  .st_halted     (st_halted)
);

// File: tb/test_ring_rx_mgr.sv
module test_ring_rx_mgr;
  localparam int PG_W  = 4;
  localparam int OFS_W = 4;
  localparam int PSZ   = 1 << OFS_W;
  localparam int FIRST = 2;
  localparam int STOP  = 10;
  localparam int AW    = PG_W + OFS_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]    rx_data = '0, rx_status = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          irq_rx_ok, irq_overwrite, st_missed, st_halted;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  logic [7:0] shadow [0:(1<<AW)-1];

  always #5 clk = ~clk;

  ring_rx_mgr #(.PG_W(PG_W), .OFS_W(OFS_W)) i_ring_rx_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_sof(rx_sof),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_status(rx_status), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq_rx_ok(irq_rx_ok),
    .irq_overwrite(irq_overwrite), .st_missed(st_missed), .st_halted(st_halted)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      shadow[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output int v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = int'(cfg_rdata);
  endtask

  task automatic send(input int len, input int base, input bit err, input int stat);
    @(negedge clk);
    rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = 8'(base + i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_eof = 1'b1; rx_err = err; rx_status = 8'(stat);
    @(negedge clk);
    rx_eof = 1'b0; rx_err = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic int step(input int p);
    return (p + 1 == STOP) ? FIRST : p + 1;
  endfunction

  function automatic int prev(input int p);
    return (p == FIRST) ? STOP - 1 : p - 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, curr, nxt, n, w0, pg, off, mism, base;
    bit wrapped;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      reg_rd(3'(a), v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 flag outputs", {st_halted, st_missed, irq_overwrite, irq_rx_ok}, 0);
    chk("R1 no write", wr_cnt, 0);

    // R11 register map
    reg_wr(3'd0, 8'(FIRST));
    reg_wr(3'd1, 8'(STOP));
    reg_wr(3'd3, 8'(FIRST));
    reg_wr(3'd2, 8'(STOP - 1));
    reg_wr(3'd4, 8'h01);
    reg_rd(3'd0, v); chk("R11 first readback", v, FIRST);
    reg_rd(3'd1, v); chk("R11 stop readback", v, STOP);
    reg_rd(3'd2, v); chk("R11 bound readback", v, STOP - 1);
    reg_rd(3'd3, v); chk("R11 curr readback", v, FIRST);
    reg_rd(3'd4, v); chk("R11 ctrl readback", v, 1);
    reg_wr(3'd4, 8'h00);
    curr = FIRST;

    // R2 R3 R4 R5 R6 length sweep
    for (int len = 0; len <= 60; len++) begin
      reg_wr(3'd5, 8'h07);
      reg_wr(3'd2, 8'(prev(curr)));
      base = len * 7 + 3;
      w0 = wr_cnt;
      send(len, base, 1'b0, len ^ 8'hA5);
      n = (len + 4 + PSZ - 1) / PSZ;
      nxt = curr;
      for (int k = 0; k < n; k++) nxt = step(nxt);
      reg_rd(3'd3, v); chk("R5 next current page", v, nxt);
      chk("R6 ok flag", int'(irq_rx_ok), 1);
      chk("R4 header status", shadow[curr*PSZ + 0], (len ^ 8'hA5) & 255);
      chk("R4 header next", shadow[curr*PSZ + 1], nxt);
      chk("R4 header count lo", shadow[curr*PSZ + 2], (len + 4) & 255);
      chk("R4 header count hi", shadow[curr*PSZ + 3], (len + 4) >> 8);
      chk("R2 write count", wr_cnt - w0, len + 4);
      pg = curr; off = 4; mism = 0; wrapped = 1'b0;
      for (int i = 0; i < len; i++) begin
        if (shadow[pg*PSZ + off] != 8'(base + i)) mism++;
        off++;
        if (off == PSZ) begin
          off = 0;
          if (pg + 1 == STOP) wrapped = 1'b1;
          pg = step(pg);
        end
      end
      chk(wrapped ? "R3 wrapped data bytes" : "R2 data bytes", mism, 0);
      curr = nxt;
    end

    // R6 flag clear
    reg_wr(3'd5, 8'h07);
    reg_rd(3'd5, v); chk("R6 flags cleared", v, 0);

    // R7 overwrite mid-frame: bound two pages ahead, 40 bytes need three pages
    reg_wr(3'd2, 8'(step(step(curr))));
    w0 = wr_cnt;
    send(40, 17, 1'b0, 1);
    chk("R7 writes stop before bound", wr_cnt - w0, (PSZ - 4) + PSZ);
    chk("R7 overwrite flag", int'(irq_overwrite), 1);
    chk("R7 missed flag", int'(st_missed), 1);
    chk("R7 halted flag", int'(st_halted), 1);
    chk("R7 no ok", int'(irq_rx_ok), 0);
    reg_rd(3'd3, v); chk("R7 current unchanged", v, curr);

    // R8 halted behaviour
    reg_wr(3'd5, 8'h07);
    w0 = wr_cnt;
    send(5, 9, 1'b0, 1);
    chk("R8 no writes while halted", wr_cnt - w0, 0);
    reg_rd(3'd5, v); chk("R8 only halted flag", v, 8);
    reg_wr(3'd2, 8'(step(step(curr))));
    chk("R8 same bound keeps halt", int'(st_halted), 1);
    reg_wr(3'd2, 8'(prev(curr)));
    chk("R8 moved bound clears halt", int'(st_halted), 0);

    // R7 overwrite at frame start
    reg_wr(3'd2, 8'(curr));
    w0 = wr_cnt;
    send(3, 1, 1'b0, 1);
    chk("R7 start overwrite no writes", wr_cnt - w0, 0);
    chk("R7 start overwrite flag", int'(irq_overwrite), 1);
    reg_wr(3'd2, 8'(prev(curr)));
    reg_wr(3'd5, 8'h07);
    reg_rd(3'd5, v); chk("R6 all flags clear", v, 0);

    // R9 monitor mode
    reg_wr(3'd4, 8'h01);
    w0 = wr_cnt;
    send(10, 5, 1'b0, 1);
    chk("R9 monitor no writes", wr_cnt - w0, 0);
    chk("R9 monitor missed", int'(st_missed), 1);
    chk("R9 monitor no overwrite", int'(irq_overwrite), 0);
    reg_rd(3'd3, v); chk("R9 current unchanged", v, curr);
    reg_wr(3'd4, 8'h00);
    reg_wr(3'd5, 8'h07);

    // R10 errored frame
    w0 = wr_cnt;
    send(20, 44, 1'b1, 1);
    chk("R10 data only, no header", wr_cnt - w0, 20);
    chk("R10 no ok", int'(irq_rx_ok), 0);
    reg_rd(3'd3, v); chk("R10 current unchanged", v, curr);

    // R5 good frame after the rejected ones starts at the same page
    send(2, 100, 1'b0, 8'h3C);
    chk("R5 resume header", shadow[curr*PSZ], 8'h3C);
    reg_rd(3'd3, v); chk("R5 resume advance", v, step(curr));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule